// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Controller

This block is the device-side logic that receives a 64 KB block-erase command on a serial flash bus and runs the erase that follows. A host lowers chip select and clocks in an 8-bit opcode followed by a 24-bit address, most significant bit first. It can send one bit per serial clock on the lowest data line, or four bits per clock on all four lines, as the mode flag selects. When chip select rises, the block checks three things. The frame must hold exactly 32 data bits. The opcode must be the block-erase code. The target block, given by address bits 23:16, must not be protected. A previously latched write enable must also be present. If all of these hold, the block starts a self-timed erase.

The serial pins, the mode flag and the data lines are sampled by a system clock through a short synchronizer chain. The edges of the serial clock and of chip select are found in that clock domain. A write-enable pulse input sets the write-enable status bit. The block drives the block number under test to an external protection lookup and reads the one-bit answer back in the same cycle. An accepted command raises the write-in-progress bit and emits a one-cycle erase request carrying the block number. The erase ends when a cycle counter reaches its programmed length, or earlier if the array reports done. At that point both write-in-progress and the write-enable bit clear.

Top module: `sflash_blk_erase`

## Requirements
- R1: An accepted frame starts an erase of the block given by address bits 23:16. That block number is presented on `erase_blk` together with the erase request and held for the whole erase.
- R2: With `qpi_mode` low, one bit is taken from `sio[0]` on each rising serial clock edge. `sio[3:1]` has no effect, so a command needs 8 opcode clocks plus 24 address clocks.
- R3: With `qpi_mode` high, four bits are taken per rising serial clock edge, with `sio[3]` as the most significant bit of each nibble. A command needs 2 opcode clocks plus 6 address clocks.
- R4: A command executes only if exactly 32 data bits were received when chip select rises. Any other count (for example 31, 33, 28 or 36) leaves `wip` at 0, gives no `erase_req`, and leaves `wel` unchanged.
- R5: The opcode must be 0xD8. Any other opcode value in a 32-bit frame is rejected with no effect on `wip`, `wel` or `erase_req`.
- R6: A command executes only if `wel` was 1 when chip select rose. Otherwise it has no effect.
- R7: When `prot_hit` is high for the block shown on `prot_blk` as chip select rises, the command is rejected, and `wel` stays 1.
- R8: An accepted command gives an `erase_req` pulse exactly one cycle long. It also holds `wip` high for exactly ERASE_CYCLES system clock cycles.
- R9: When the erase completes, `wip` and `wel` both go to 0 in the same cycle. An `erase_done` pulse during an erase ends it at the next clock edge.
- R10: While `wip` is 1, complete erase frames and `wren_pulse` have no effect. This holds in the completion cycle too: the block, the duration and the final `wel` of 0 are unchanged.
- R11: A `wren_pulse` while idle sets `wel` at the next clock edge.
- R12: After reset, `wip`, `wel` and `erase_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sio | input | 4 | Serial data lines; only bit 0 is used in single-bit mode |
| qpi_mode | input | 1 | 1 selects four bits per clock, 0 selects one bit per clock |
| wren_pulse | input | 1 | Write-enable command pulse |
| prot_blk | output | 8 | Block number offered to the protection lookup |
| prot_hit | input | 1 | 1 when the block on `prot_blk` is protected |
| erase_done | input | 1 | Early completion report from the array |
| erase_req | output | 1 | One-cycle request to start erasing `erase_blk` |
| erase_blk | output | 8 | Block being erased |
| wip | output | 1 | Write-in-progress status bit |
| wel | output | 1 | Write-enable-latch status bit |

## Verification
The collision that matters is erase completion, which clears the write-enable bit, arriving in the same cycle as a write-enable pulse. A second case is a fresh erase frame that ends while the block is still busy. The bench provokes the first by holding `wren_pulse` high for the whole erase and releasing it in the cycle where `wip` is first seen low. The final `wel` must then be 0. The second case is provoked by sending a valid frame for another block in the middle of an erase. That case is judged by an unchanged `erase_blk`, a `wip` duration of exactly ERASE_CYCLES, and a single request pulse.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS) + 1;
  localparam int unsigned BLK_W      = 8;
  localparam logic [7:0]  OPC_BLK_ERASE = 8'hD8;

  // bit counter step, saturating at all ones so long frames never wrap to 32
  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c,
                                                input logic quad);
    logic [CNT_W:0] sum;
    sum = {1'b0, c} + (quad ? (CNT_W+1)'(4) : (CNT_W+1)'(1));
    return sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  endfunction

  // shift register update: one bit from line 0 or one nibble, MSB first
  function automatic logic [FRAME_BITS-1:0] shift_in(input logic [FRAME_BITS-1:0] s,
                                                     input logic [3:0] d,
                                                     input logic quad);
    return quad ? {s[FRAME_BITS-5:0], d} : {s[FRAME_BITS-2:0], d[0]};
  endfunction

  function automatic logic frame_is_erase(input logic [7:0] opc,
                                          input logic [CNT_W-1:0] c);
    return (opc == OPC_BLK_ERASE) && (c == CNT_W'(FRAME_BITS));
  endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int unsigned W = 7,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stage[i-1].r;
    end
  end
  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/sfe_frame.sv
module sfe_frame
  import sfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_s,
  input  logic             sclk_s,
  input  logic [3:0]       sio_s,
  input  logic             quad_s,
  output logic             frame_end,
  output logic [7:0]       opcode,
  output logic [BLK_W-1:0] blk,
  output logic [CNT_W-1:0] cnt
);
  logic                  sclk_q, cs_q;
  logic [FRAME_BITS-1:0] shreg;
  logic                  sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_q & ~cs_n_s;
  assign frame_end = cs_n_s & ~cs_q;
  assign opcode    = shreg[FRAME_BITS-1 -: 8];
  assign blk       = shreg[FRAME_BITS-9 -: BLK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      shreg  <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_n_s;
      if (cs_n_s) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        cnt   <= cnt_step(cnt, quad_s);
        shreg <= shift_in(shreg, sio_s, quad_s);
      end
    end
  end
endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
  import sfe_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wren_pulse,
  input  logic             frame_ok,
  input  logic [BLK_W-1:0] blk_in,
  input  logic             prot_hit,
  input  logic             erase_done,
  output logic             wip,
  output logic             wel,
  output logic             erase_req,
  output logic [BLK_W-1:0] erase_blk,
  output logic             cmd_accept,
  output logic             erase_finish
);
  localparam int unsigned TMR_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(ERASE_CYCLES - 1);

  logic [TMR_W-1:0] tmr;
  logic             timer_hit;

  assign cmd_accept   = frame_ok & wel & ~prot_hit & ~wip;
  assign timer_hit    = (tmr == TMR_LAST);
  assign erase_finish = wip & (timer_hit | erase_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip       <= 1'b0;
      wel       <= 1'b0;
      erase_req <= 1'b0;
      erase_blk <= '0;
      tmr       <= '0;
    end else begin
      erase_req <= cmd_accept;
      if (cmd_accept) begin
        wip       <= 1'b1;
        erase_blk <= blk_in;
        tmr       <= '0;
      end else if (wip) begin
        if (erase_finish) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end else if (wren_pulse) begin
        wel <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sflash_blk_erase.sv
module sflash_blk_erase
  import sfe_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 4096,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [3:0]       sio,
  input  logic             qpi_mode,
  input  logic             wren_pulse,
  output logic [BLK_W-1:0] prot_blk,
  input  logic             prot_hit,
  input  logic             erase_done,
  output logic             erase_req,
  output logic [BLK_W-1:0] erase_blk,
  output logic             wip,
  output logic             wel
);
  localparam int unsigned SYNC_W = 7;

  logic [SYNC_W-1:0] pins_s;
  logic              cs_n_s, sclk_s, quad_s;
  logic [3:0]        sio_s;
  logic              frame_end, frame_ok, cmd_accept, erase_finish;
  logic [7:0]        frame_op;
  logic [CNT_W-1:0]  frame_cnt;

  sfe_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(7'b1000000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sclk, qpi_mode, sio}),
    .q(pins_s)
  );
  assign cs_n_s = pins_s[6];
  assign sclk_s = pins_s[5];
  assign quad_s = pins_s[4];
  assign sio_s  = pins_s[3:0];

  sfe_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sio_s(sio_s), .quad_s(quad_s),
    .frame_end(frame_end), .opcode(frame_op), .blk(prot_blk), .cnt(frame_cnt)
  );

  assign frame_ok = frame_end & frame_is_erase(frame_op, frame_cnt);

  sfe_seq #(.ERASE_CYCLES(ERASE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wren_pulse(wren_pulse), .frame_ok(frame_ok), .blk_in(prot_blk),
    .prot_hit(prot_hit), .erase_done(erase_done),
    .wip(wip), .wel(wel), .erase_req(erase_req), .erase_blk(erase_blk),
    .cmd_accept(cmd_accept), .erase_finish(erase_finish)
  );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker
  import sfe_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_accept,
  input logic             erase_finish,
  input logic [CNT_W-1:0] frame_cnt,
  input logic [7:0]       frame_op,
  input logic             prot_hit,
  input logic [BLK_W-1:0] prot_blk,
  input logic             wip,
  input logic             wel,
  input logic             erase_req,
  input logic [BLK_W-1:0] erase_blk
);
  p_exact_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> (frame_cnt == CNT_W'(32)));
  p_opcode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> (frame_op == 8'hD8));
  p_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> wel);
  p_unprotected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> !prot_hit);
  p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> (wip && erase_req && erase_blk == $past(prot_blk)));
  p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
  p_wip_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cmd_accept));
  p_finish_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_finish |=> (!wip && !wel));
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && !erase_finish) |=> (wip && $stable(erase_blk)));
  p_busy_no_wel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> !$rose(wel));
endmodule

bind sflash_blk_erase sfe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept), .erase_finish(erase_finish),
  .frame_cnt(frame_cnt), .frame_op(frame_op), .prot_hit(prot_hit),
  .prot_blk(prot_blk), .wip(wip), .wel(wel), .erase_req(erase_req),
  .erase_blk(erase_blk)
);

// File: tb/sflash_blk_erase_tb.sv
`timescale 1ns/1ps
module sflash_blk_erase_tb_top;
  localparam int EC   = 400;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, qpi_mode = 1'b0, wren_pulse = 1'b0;
  logic       erase_done = 1'b0;
  logic [3:0] sio = 4'h0;
  logic [7:0] prot_blk, erase_blk;
  logic       prot_hit, erase_req, wip, wel;

  int total = 0, fails = 0, wip_cyc = 0, req_cnt = 0;
  bit finished = 1'b0;
  bit m_wel = 1'b0;

  always #2.5 clk = ~clk;

  function automatic bit is_prot(input logic [7:0] b);
    return b[2:0] == 3'b101;
  endfunction
  assign prot_hit = is_prot(prot_blk);

  function automatic bit expect_run(input logic [7:0] opc, input int nbits,
                                    input bit we, input logic [7:0] b);
    return (opc == 8'hD8) && (nbits == 32) && we && !is_prot(b);
  endfunction

  sflash_blk_erase #(.ERASE_CYCLES(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sio(sio),
    .qpi_mode(qpi_mode), .wren_pulse(wren_pulse), .prot_blk(prot_blk),
    .prot_hit(prot_hit), .erase_done(erase_done), .erase_req(erase_req),
    .erase_blk(erase_blk), .wip(wip), .wel(wel)
  );

  always @(posedge clk) begin
    #1;
    if (wip) wip_cyc++;
    if (erase_req) req_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wren_now();
    @(negedge clk) wren_pulse = 1'b1;
    @(negedge clk) wren_pulse = 1'b0;
    if (!wip) m_wel = 1'b1;
  endtask

  task automatic beat(input logic [3:0] d);
    sio = d;
    cyc(HALF);
    sclk = 1'b1;
    cyc(HALF);
    sclk = 1'b0;
  endtask

  task automatic send(input bit quad, input logic [7:0] opc,
                      input logic [23:0] addr, input int nbits);
    logic [31:0] w;
    w = {opc, addr};
    qpi_mode = quad;
    cyc(2);
    cs_n = 1'b0;
    cyc(HALF);
    if (quad) begin
      for (int k = 0; k < nbits / 4; k++)
        beat(k < 8 ? w[31-4*k -: 4] : 4'($urandom));
    end else begin
      for (int k = 0; k < nbits; k++)
        beat({3'($urandom), (k < 32) ? w[31-k] : 1'($urandom)});
    end
    cyc(HALF);
    cs_n = 1'b1;
  endtask

  task automatic run(input bit quad, input logic [7:0] opc, input logic [23:0] addr,
                     input int nbits, input string tag);
    bit acc;
    acc = expect_run(opc, nbits, m_wel, addr[23:16]);
    cyc(1);
    wip_cyc = 0;
    req_cnt = 0;
    send(quad, opc, addr, nbits);
    cyc(EC + 20);
    chk(req_cnt == int'(acc), {tag, " request count"}, req_cnt, int'(acc));
    chk(wip_cyc == (acc ? EC : 0), {tag, " wip cycles R8"}, wip_cyc, acc ? EC : 0);
    if (acc) begin
      chk(erase_blk == addr[23:16], {tag, " erase_blk R1"}, erase_blk, addr[23:16]);
      m_wel = 1'b0;
    end
    chk(wel == m_wel, {tag, " wel after"}, wel, m_wel);
    chk(wip == 1'b0, {tag, " wip idle"}, wip, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    // R12 reset state
    chk(wip == 1'b0, "R12 wip reset", wip, 0);
    chk(wel == 1'b0, "R12 wel reset", wel, 0);
    chk(erase_req == 1'b0, "R12 erase_req reset", erase_req, 0);

    // R11 write enable while idle
    @(negedge clk) wren_pulse = 1'b1;
    @(negedge clk) wren_pulse = 1'b0;
    chk(wel == 1'b1, "R11 wel set next edge", wel, 1);
    m_wel = 1'b1;

    // R1 R2 single-bit frame, upper lines random
    run(1'b0, 8'hD8, 24'h21_ABCD, 32, "R2 spi valid");
    // R3 four-bit frame
    wren_now();
    run(1'b1, 8'hD8, 24'hA6_0F0F, 32, "R3 qpi valid");

    // R4 wrong counts, wel stays set
    wren_now();
    run(1'b0, 8'hD8, 24'h10_0000, 31, "R4 spi 31");
    run(1'b0, 8'hD8, 24'h10_0000, 33, "R4 spi 33");
    run(1'b1, 8'hD8, 24'h10_0000, 28, "R4 qpi 28");
    run(1'b1, 8'hD8, 24'h10_0000, 36, "R4 qpi 36");
    // R5 other opcode
    run(1'b0, 8'h20, 24'h10_0000, 32, "R5 opcode 20");
    run(1'b1, 8'hD9, 24'h10_0000, 32, "R5 opcode D9");
    // clear wel with a good erase, then R6 without write enable
    run(1'b1, 8'hD8, 24'h08_0000, 32, "R9 clear wel");
    run(1'b1, 8'hD8, 24'h08_0000, 32, "R6 no wel");
    // R7 protected block
    wren_now();
    run(1'b0, 8'hD8, 24'h35_1234, 32, "R7 protected");
    chk(wel == 1'b1, "R7 wel kept", wel, 1);

    // R10 frame and write enable during erase
    cyc(1);
    wip_cyc = 0;
    req_cnt = 0;
    send(1'b1, 8'hD8, 24'h12_0000, 32);
    cyc(8);
    chk(wip == 1'b1, "R8 wip raised", wip, 1);
    wren_now();
    send(1'b1, 8'hD8, 24'h44_0000, 32);
    for (int i = 0; i < EC && wip; i++) cyc(1);
    cyc(20);
    chk(wip_cyc == EC, "R10 duration unchanged", wip_cyc, EC);
    chk(req_cnt == 1, "R10 single request", req_cnt, 1);
    chk(erase_blk == 8'h12, "R10 block unchanged", erase_blk, 8'h12);
    chk(wel == 1'b0, "R9 wel cleared", wel, 0);
    m_wel = 1'b0;

    // R10 write enable held through the completion cycle
    wren_now();
    send(1'b1, 8'hD8, 24'h02_0000, 32);
    for (int i = 0; i < 50 && !wip; i++) cyc(1);
    wren_pulse = 1'b1;
    for (int i = 0; i < EC + 10 && wip; i++) cyc(1);
    wren_pulse = 1'b0;
    cyc(1);
    chk(wel == 1'b0, "R10 wren at finish ignored", wel, 0);
    chk(wip == 1'b0, "R9 wip cleared", wip, 0);

    // R9 early done from the array
    wren_now();
    send(1'b0, 8'hD8, 24'h03_0000, 32);
    cyc(50);
    chk(wip == 1'b1, "R9 busy before done", wip, 1);
    erase_done = 1'b1;
    @(negedge clk) erase_done = 1'b0;
    chk(wip == 1'b0, "R9 done ends erase", wip, 0);
    chk(wel == 1'b0, "R9 done clears wel", wel, 0);
    m_wel = 1'b0;

    // random mix, R4 R5 R6 R7 R8 judged by the model
    for (int it = 0; it < 40; it++) begin
      bit quad, we;
      logic [7:0] opc;
      logic [23:0] addr;
      int nb, sel;
      quad = 1'($urandom);
      we = ($urandom % 4) != 0;
      opc = (($urandom % 6) == 0) ? 8'hC7 ^ 8'($urandom % 16) : 8'hD8;
      sel = $urandom % 8;
      nb = 32;
      if (sel == 5) nb = quad ? 28 : 31;
      if (sel == 6) nb = quad ? 36 : 33;
      if (sel == 7) nb = 24;
      addr = 24'($urandom);
      if (we) wren_now();
      run(quad, opc, addr, nb, "R4 R5 R6 R7 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule